// File: doc/BRIEF.md
# Timer Channel Compare and Capture Pin Controller

This block is the pin-facing part of one timer channel. The channel has two general registers, A and B. A 4-bit field in a shared control byte sets each register to one of two modes. In output-compare mode, the register drives an output pin when the free-running counter reaches its value. In input-capture mode, the register latches the counter on a trigger. The trigger is either an edge on the register's own input pin or an event strobe from a neighbouring channel. The counter is supplied from outside, and the block only reads it.

Software reaches the control byte and both general registers through a plain register port. A write always completes in the cycle it is presented. A read returns data combinationally from the read address. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. All pins are plain level signals.

Register map on `wr_addr_i` and `rd_addr_i`:
- 0: control byte.
- 1: general register A.
- 2: general register B.
- 3: unmapped.

In the control byte, register A's field is bits 3..0 and register B's field is bits 7..4.

Top module: `tmr_io_chan`

## Requirements
- R1: After reset, every readable location returns 0 and both output pins are low.
- R2: Reads return the following:
  - Address 0: the control byte, zero-extended. Bits 3..0 are field A and bits 7..4 are field B.
  - Address 1: general register A.
  - Address 2: general register B.
  - Address 3: always 0.

  A write to address 0 replaces the whole byte from data bits 7..0.
- R3: When a field's bit 3 is 0, the register is in compare mode. Writing a compare-mode field sets that register's pin, on the next clock, to the field's bit 2 (the initial level).
- R4: In compare mode with field bits 1..0 = 00, the output action is disabled. The pin is then driven to field bit 2 on every clock.
- R5: In compare mode, a match occurs when the counter equals the general register. On the clock after a match, the pin takes the action set by bits 1..0:
  - 01 drives the pin low.
  - 10 drives the pin high.
  - 11 inverts the pin.

  Without a match, the pin holds its level.
- R6: When bit 3 is 1, the register is in capture mode, and codes 10xx take the pin as the trigger source:
  - 1000 triggers on a rising edge.
  - 1001 triggers on a falling edge.
  - 101x triggers on either edge.

  The pin passes through a two-flop synchronizer. A level change that is set up before clock k is captured at clock k+2, with the counter value present at that edge.
- R7: Codes 11xx in capture mode take the trigger from the neighbouring channel's strobe instead of the pin. Register A uses `xev_a_i` and register B uses `xev_b_i`. The register loads the counter at the same clock edge where the strobe is high.
- R8: If a capture and a bus write to the same general register occur in the same cycle, the captured counter value is stored.
- R9: In capture mode, the register's output pin holds its level.
- R10: A bus write to a general register is stored in either mode when no capture occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| pin_a_i | input | 1 | Capture pin for register A (asynchronous) |
| pin_b_i | input | 1 | Capture pin for register B (asynchronous) |
| xev_a_i | input | 1 | Neighbour event strobe used by register A in cross-channel mode |
| xev_b_i | input | 1 | Neighbour event strobe used by register B in cross-channel mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CNT_W | Read data, combinational from rd_addr_i |
| pin_a_o | output | 1 | Output pin driven by register A |
| pin_b_o | output | 1 | Output pin driven by register B |

## Verification
A wrong field decode or a wrong pin register shows on `pin_a_o` or `pin_b_o` at the first clock after the write or match that should have set the level. In disabled-output mode, it shows on every clock. A corrupted synchronizer or edge history shows up later, when a general register is read back. That read comes two clocks after the pin change, holding the wrong counter value or none at all. Because the bench reads a random address every cycle and compares both pins every cycle, a bad stored value surfaces within a few cycles of the event that produced it.

// File: rtl/tmr_io_pkg.sv
package tmr_io_pkg;
  localparam int NUM_GR  = 2;
  localparam int FIELD_W = 4;
  localparam int CTL_W   = NUM_GR * FIELD_W;

  typedef enum logic [1:0] {
    ADR_CTL  = 2'd0,
    ADR_GRA  = 2'd1,
    ADR_GRB  = 2'd2,
    ADR_NONE = 2'd3
  } tmr_adr_e;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_TGL  = 2'd3
  } tmr_act_e;
endpackage

// File: rtl/tmr_io_edge.sv
module tmr_io_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[LAST] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[LAST] &  sh_q[STAGES];
endmodule

// File: rtl/tmr_io_unit.sv
module tmr_io_unit
  import tmr_io_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       field_i,
  input  logic             field_we_i,
  input  logic [1:0]       field_new_hi_i,
  input  logic             gr_we_i,
  input  logic [CNT_W-1:0] gr_wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             xev_i,
  output logic [CNT_W-1:0] gr_o,
  output logic             pin_o,
  output logic             cap_o
);
  logic             rise, fall, trig, match;
  logic [CNT_W-1:0] gr_q;
  logic             pin_q;
  tmr_act_e         act;

  tmr_io_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  // bit3 = capture, bit2 = cross-channel source, bit1 = both edges, bit0 = falling
  always_comb begin
    if (!field_i[3])     trig = 1'b0;
    else if (field_i[2]) trig = xev_i;
    else if (field_i[1]) trig = rise | fall;
    else if (field_i[0]) trig = fall;
    else                 trig = rise;
  end

  assign act   = tmr_act_e'(field_i[1:0]);
  assign match = !field_i[3] && (cnt_i == gr_q);

  // capture wins over the bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gr_q <= '0;
    else if (trig)    gr_q <= cnt_i;
    else if (gr_we_i) gr_q <= gr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (field_we_i && !field_new_hi_i[1]) begin
      pin_q <= field_new_hi_i[0];
    end else if (!field_i[3]) begin
      unique case (act)
        ACT_OFF:  pin_q <= field_i[2];
        ACT_LOW:  if (match) pin_q <= 1'b0;
        ACT_HIGH: if (match) pin_q <= 1'b1;
        ACT_TGL:  if (match) pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assign gr_o  = gr_q;
  assign pin_o = pin_q;
  assign cap_o = trig;
endmodule

// File: rtl/tmr_io_chan.sv
module tmr_io_chan
  import tmr_io_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             xev_a_i,
  input  logic             xev_b_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             pin_a_o,
  output logic             pin_b_o
);
  logic [CTL_W-1:0]             ctl_q;
  logic                         ctl_we;
  logic [NUM_GR-1:0][CNT_W-1:0] gr_q;
  logic [NUM_GR-1:0]            pin_q, cap_hit, pin_in, xev_in;

  assign ctl_we = wr_en_i && (wr_addr_i == ADR_CTL);
  assign pin_in = {pin_b_i, pin_a_i};
  assign xev_in = {xev_b_i, xev_a_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= wr_data_i[CTL_W-1:0];
  end

  for (genvar gi = 0; gi < NUM_GR; gi++) begin : g_unit
    localparam tmr_adr_e GR_ADR = (gi == 0) ? ADR_GRA : ADR_GRB;
    logic gr_we;
    assign gr_we = wr_en_i && (wr_addr_i == GR_ADR);

    tmr_io_unit #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .field_i       (ctl_q[FIELD_W*gi +: FIELD_W]),
      .field_we_i    (ctl_we),
      .field_new_hi_i(wr_data_i[FIELD_W*gi+2 +: 2]),
      .gr_we_i       (gr_we),
      .gr_wdata_i    (wr_data_i),
      .cnt_i         (cnt_i),
      .pin_i         (pin_in[gi]),
      .xev_i         (xev_in[gi]),
      .gr_o          (gr_q[gi]),
      .pin_o         (pin_q[gi]),
      .cap_o         (cap_hit[gi])
    );
  end

  always_comb begin
    unique case (tmr_adr_e'(rd_addr_i))
      ADR_CTL: rd_data_o = CNT_W'(ctl_q);
      ADR_GRA: rd_data_o = gr_q[0];
      ADR_GRB: rd_data_o = gr_q[1];
      default: rd_data_o = '0;
    endcase
  end

  assign pin_a_o = pin_q[0];
  assign pin_b_o = pin_q[1];
endmodule

// File: rtl/tmr_io_chan_chk.sv
module tmr_io_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            ctl,
  input logic                  ctl_we,
  input logic [7:0]            ctl_new,
  input logic [CNT_W-1:0]      cnt,
  input logic [1:0][CNT_W-1:0] gr,
  input logic [1:0]            pin,
  input logic [1:0]            cap
);
  for (genvar gi = 0; gi < 2; gi++) begin : g_chk
    logic [3:0] f;
    assign f = ctl[4*gi +: 4];

    p_init_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_new[4*gi+3]) |=> (pin[gi] == $past(ctl_new[4*gi+2])));

    p_disabled_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !f[3] && f[1:0] == 2'b00) |=> (pin[gi] == $past(f[2])));

    p_match_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && f == 4'b0001 || !ctl_we && f == 4'b0101) && cnt == gr[gi] |=> !pin[gi]);

    p_match_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !f[3] && f[1:0] == 2'b10 && cnt == gr[gi]) |=> pin[gi]);

    p_match_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !f[3] && f[1:0] == 2'b11 && cnt == gr[gi]) |=> (pin[gi] != $past(pin[gi])));

    p_no_match_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !f[3] && f[1:0] != 2'b00 && cnt != gr[gi]) |=> $stable(pin[gi]));

    p_capture_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap[gi] |=> (gr[gi] == $past(cnt)));

    p_capture_pin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && f[3]) |=> $stable(pin[gi]));

    p_compare_no_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !f[3] |-> !cap[gi]);
  end
endmodule

bind tmr_io_chan tmr_io_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ctl    (ctl_q),
  .ctl_we (ctl_we),
  .ctl_new(wr_data_i[7:0]),
  .cnt    (cnt_i),
  .gr     (gr_q),
  .pin    (pin_q),
  .cap    (cap_hit)
);

// File: tb/tmr_io_chan_test.sv
`timescale 1ns/1ps
module tmr_io_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        pin_a_i = 1'b0, pin_b_i = 1'b0, xev_a_i = 1'b0, xev_b_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        pin_a_o, pin_b_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] cnt8 = '0;

  always #4 clk = ~clk;

  tmr_io_chan #(.CNT_W(16), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
    .pin_a_i(pin_a_i), .pin_b_i(pin_b_i), .xev_a_i(xev_a_i), .xev_b_i(xev_b_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .pin_a_o(pin_a_o), .pin_b_o(pin_b_o)
  );

  // behavioural reference state
  logic [7:0]  m_ctl;
  logic [15:0] m_gr [2];
  logic        m_pin [2];
  logic        m_hist [2][$];
  logic [3:0]  f, nf;
  logic        pin_now, x_now, late, older, ev, cw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0;
      for (int i = 0; i < 2; i++) begin
        m_gr[i] = '0; m_pin[i] = 1'b0;
        m_hist[i] = '{1'b0, 1'b0, 1'b0};
      end
    end else begin
      cw = wr_en_i && wr_addr_i == 2'd0;
      for (int i = 0; i < 2; i++) begin
        f = m_ctl[4*i +: 4];
        nf = wr_data_i[4*i +: 4];
        pin_now = (i == 0) ? pin_a_i : pin_b_i;
        x_now = (i == 0) ? xev_a_i : xev_b_i;
        late = m_hist[i][1];   // value seen after two sync stages
        older = m_hist[i][2];  // one clock earlier
        ev = 1'b0;
        if (f[3]) begin
          if (f[2]) ev = x_now;
          else if (f[1]) ev = (late != older);
          else if (f[0]) ev = older && !late;
          else ev = late && !older;
        end
        if (cw && !nf[3]) m_pin[i] = nf[2];
        else if (!f[3]) begin
          if (f[1:0] == 2'b00) m_pin[i] = f[2];
          else if (cnt_i == m_gr[i]) begin
            if (f[1:0] == 2'b01) m_pin[i] = 1'b0;
            else if (f[1:0] == 2'b10) m_pin[i] = 1'b1;
            else m_pin[i] = !m_pin[i];
          end
        end
        if (ev) m_gr[i] = cnt_i;
        else if (wr_en_i && wr_addr_i == 2'(i + 1)) m_gr[i] = wr_data_i;
        m_hist[i].push_front(pin_now);
        void'(m_hist[i].pop_back());
      end
      if (cw) m_ctl = wr_data_i[7:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [15:0] exp_rd;
    case (rd_addr_i)
      2'd0: exp_rd = {8'h00, m_ctl};
      2'd1: exp_rd = m_gr[0];
      2'd2: exp_rd = m_gr[1];
      default: exp_rd = '0;
    endcase
    chk(pin_a_o === m_pin[0], "R3 R4 R5 R9 pin A", {15'd0, pin_a_o}, {15'd0, m_pin[0]});
    chk(pin_b_o === m_pin[1], "R3 R4 R5 R9 pin B", {15'd0, pin_b_o}, {15'd0, m_pin[1]});
    chk(rd_data_o === exp_rd, "R2 R6 R7 R8 R10 read", rd_data_o, exp_rd);
  endtask

  task automatic cyc(input bit w, input logic [1:0] a, input logic [15:0] d, input bit fx);
    @(negedge clk);
    compare_all();
    wr_en_i = w; wr_addr_i = a; wr_data_i = d;
    cnt8 = cnt8 + 8'd1;
    cnt_i = {8'h00, cnt8};
    if ($urandom % 8 == 0) pin_a_i = !pin_a_i;
    if ($urandom % 8 == 0) pin_b_i = !pin_b_i;
    xev_a_i = fx | ($urandom % 16 == 0);
    xev_b_i = fx | ($urandom % 16 == 0);
    rd_addr_i = 2'($urandom % 4);
  endtask

  task automatic run_phase(input logic [7:0] ctl, input int n);
    cyc(1'b1, 2'd0, {8'h00, ctl}, 1'b0);
    for (int k = 0; k < n; k++) begin
      if ($urandom % 24 == 0) cyc(1'b1, 2'(1 + $urandom % 2), 16'($urandom % 256), 1'b0);
      else cyc(1'b0, 2'd0, 16'd0, 1'b0);
    end
  endtask

  initial begin
    logic [15:0] cap_val;
    repeat (3) @(negedge clk);
    // R1: reset state at every address
    for (int a = 0; a < 4; a++) begin
      rd_addr_i = 2'(a); #1;
      chk(rd_data_o === 16'd0, "R1 reset read", rd_data_o, 16'd0);
    end
    chk(pin_a_o === 1'b0 && pin_b_o === 1'b0, "R1 reset pins", {14'd0, pin_b_o, pin_a_o}, 16'd0);
    rst_n = 1'b1;

    run_phase(8'h53, 600);  // B 0101 init1 drive0, A 0011 toggle
    run_phase(8'h62, 600);  // B 0110 drive1 init1, A 0010 drive1
    run_phase(8'h47, 600);  // B disabled init1, A toggle init1
    run_phase(8'h00, 300);
    run_phase(8'h98, 600);  // B falling, A rising
    run_phase(8'hA8, 600);  // B both edges, A rising
    run_phase(8'h19, 600);  // B compare, A falling
    run_phase(8'hCC, 600);  // both cross-channel
    run_phase(8'hBF, 600);  // B both edges, A cross

    // R8: capture and bus write collide on register A
    run_phase(8'hCC, 4);
    cyc(1'b1, 2'd1, 16'h00EE, 1'b1);
    cap_val = cnt_i;
    @(negedge clk);
    wr_en_i = 1'b0; xev_a_i = 1'b0; xev_b_i = 1'b0;
    rd_addr_i = 2'd1; #1;
    chk(rd_data_o === cap_val, "R8 capture over write", rd_data_o, cap_val);
    // R10: bus write stored in capture mode without a capture
    cyc(1'b1, 2'd1, 16'h0077, 1'b0);
    xev_a_i = 1'b0; xev_b_i = 1'b0;
    @(negedge clk);
    wr_en_i = 1'b0; rd_addr_i = 2'd1; #1;
    chk(rd_data_o === 16'h0077, "R10 write in capture mode", rd_data_o, 16'h0077);
    run_phase(8'h00, 50);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule